// File: doc/BRIEF.md
# Two-Source Interrupt Front End

This block sits between two external interrupt pins, a timer overflow strobe and the sequencer of a small 4-bit controller. Each pin passes through a two-stage synchronizer. A rising edge on the synchronized level raises an input request, but only while that pin's mask flag is clear. The same edge then sets the mask. A timer overflow sets a timer flag and raises a timer request. Requests stay latched until they are taken.

A global enable gates acceptance. While it is set, a latched request is taken in the same cycle it becomes visible: `take_o` rises and `vec_o` carries a fixed jump target. At the next edge the serviced latch clears, the enable clears, and `pc_i` is pushed onto a four-deep return stack. Pin requests outrank a pending timer request, which stays latched and is taken after a return-with-enable. Software can set or clear the masks, clear the timer flag, set or clear the enable, and read every flag and the synchronized pin levels.

Top module: `irq_front_ctrl`

## Requirements
- R1: After reset, `gie_o`, `in_req_o`, `tmr_req_o`, `tflag_o`, `mask_o`, `pin_lvl_o`, `stack_top_o` and `take_o` are all 0.
- R2: A pin driven high is synchronized by two flops and appears on `pin_lvl_o` after two clock edges. The resulting request and mask appear after the third edge.
- R3: A rising edge raises an input request only when that pin's mask is clear. Every rising edge sets that pin's mask. Masks are bit 0 for pin 0 and bit 1 for pin 1.
- R4: Mask flags favour set. When `mask_clr_i` meets a rising edge or `mask_set_i` in the same cycle, the mask ends up set, and a request from a clear mask is still latched.
- R5: `tmr_ovf_i` sets `tflag_o` and `tmr_req_o`. It wins over `tflag_clr_i` in the same cycle.
- R6: While the enable is 0, a latched request stays at 1.
- R7: With the enable at 1 and a request latched, `take_o` and `push_o` are 1 in that cycle. The next edge clears the serviced latch and the enable.
- R8: If both latches are set, the pin request is taken first, and `tmr_req_o` stays 1 across that acceptance.
- R9: `vec_o` is {page, 6-bit address}, with the page in the upper 4 bits. It is 0x07F (page 1, address 0x3F) for a pin interrupt, 0x03F (page 0, address 0x3F) for a timer interrupt, and 0 when nothing is taken.
- R10: Acceptance pushes `pc_i` onto the stack top and shifts the older entries down, dropping the fourth. A return pops the stack and fills the bottom with 0. `stack_top_o` shows the top entry.
- R11: `reti_i` pops the stack and sets the enable. `ret_i` pops the stack and leaves the enable unchanged.
- R12: `gie_set_i` sets the enable and `gie_clr_i` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 2 | Raw interrupt pins |
| tmr_ovf_i | input | 1 | Timer overflow strobe |
| mask_set_i | input | 2 | Software set of the pin masks |
| mask_clr_i | input | 2 | Software clear of the pin masks |
| tflag_clr_i | input | 1 | Software clear of the timer flag |
| gie_set_i | input | 1 | Set the global enable |
| gie_clr_i | input | 1 | Clear the global enable |
| ret_i | input | 1 | Plain return (pop) |
| reti_i | input | 1 | Return with enable (pop and set enable) |
| pc_i | input | 10 | Return address to push |
| take_o | output | 1 | Interrupt accepted this cycle |
| vec_o | output | 10 | Jump target |
| push_o | output | 1 | Stack push strobe |
| gie_o | output | 1 | Global enable |
| in_req_o | output | 1 | Input request latch |
| tmr_req_o | output | 1 | Timer request latch |
| tflag_o | output | 1 | Timer flag |
| mask_o | output | 2 | Pin mask flags |
| pin_lvl_o | output | 2 | Synchronized pin levels |
| stack_top_o | output | 10 | Top of return stack |

## Verification
Two pairs of functions can land on the same edge: a software flag clear with the hardware event that sets the same flag, and a pin request with a pending timer request. The first pair is provoked in two ways. A pin is driven high so that its third edge coincides with a mask clear, and an overflow is issued together with a timer-flag clear. In both cases the flag must read set afterwards and the request must be latched. The second pair is provoked by holding a timer request while a pin request arrives, then enabling. The pin vector must come out first and the timer latch must stay set until the return-with-enable.

// File: rtl/irq_front_pkg.sv
package irq_front_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PIN  = 2'd1,
    SRC_TMR  = 2'd2
  } irq_src_e;
endpackage

// File: rtl/irq_pin_edge.sv
module irq_pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic mask_set_i,
  input  logic mask_clr_i,
  output logic lvl_o,
  output logic raise_o,
  output logic mask_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic prev_q, mask_q, rise;

  assign lvl_o   = sync_q[SYNC_STAGES-1];
  assign rise    = lvl_o & ~prev_q;
  assign raise_o = rise & ~mask_q;
  assign mask_o  = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
      prev_q <= lvl_o;
      // set wins over software clear
      if (rise || mask_set_i) mask_q <= 1'b1;
      else if (mask_clr_i)    mask_q <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_front_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     pin_raise_i,
  input  logic     tmr_ovf_i,
  input  logic     tflag_clr_i,
  input  logic     gie_set_i,
  input  logic     gie_clr_i,
  input  logic     reti_i,
  output logic     take_o,
  output irq_src_e src_o,
  output logic     gie_o,
  output logic     in_req_o,
  output logic     tmr_req_o,
  output logic     tflag_o
);
  logic gie_q, in_req_q, tmr_req_q, tflag_q;
  logic take_pin, take_tmr;

  assign take_pin = gie_q & in_req_q;
  assign take_tmr = gie_q & tmr_req_q & ~in_req_q;
  assign take_o   = take_pin | take_tmr;

  always_comb begin
    src_o = SRC_NONE;
    if (take_pin)      src_o = SRC_PIN;
    else if (take_tmr) src_o = SRC_TMR;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q     <= 1'b0;
      in_req_q  <= 1'b0;
      tmr_req_q <= 1'b0;
      tflag_q   <= 1'b0;
    end else begin
      if (pin_raise_i)   in_req_q <= 1'b1;
      else if (take_pin) in_req_q <= 1'b0;

      if (tmr_ovf_i)     tmr_req_q <= 1'b1;
      else if (take_tmr) tmr_req_q <= 1'b0;

      if (tmr_ovf_i)        tflag_q <= 1'b1;
      else if (tflag_clr_i) tflag_q <= 1'b0;

      if (take_o)                   gie_q <= 1'b0;
      else if (reti_i || gie_set_i) gie_q <= 1'b1;
      else if (gie_clr_i)           gie_q <= 1'b0;
    end
  end

  assign gie_o     = gie_q;
  assign in_req_o  = in_req_q;
  assign tmr_req_o = tmr_req_q;
  assign tflag_o   = tflag_q;
endmodule

// File: rtl/irq_pc_stack.sv
module irq_pc_stack #(
  parameter int DEPTH = 4,
  parameter int W     = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);
  logic [W-1:0] st_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
    logic [W-1:0] from_above, from_below;
    if (i == 0) begin : g_first
      assign from_above = data_i;
    end else begin : g_mid_a
      assign from_above = st_q[i-1];
    end
    if (i == DEPTH-1) begin : g_last
      assign from_below = '0;
    end else begin : g_mid_b
      assign from_below = st_q[i+1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[i] <= '0;
      end else if (push_i && pop_i) begin
        if (i == 0) st_q[i] <= data_i;
      end else if (push_i) begin
        st_q[i] <= from_above;
      end else if (pop_i) begin
        st_q[i] <= from_below;
      end
    end
  end

  assign top_o = st_q[0];
endmodule

// File: rtl/irq_front_ctrl.sv
module irq_front_ctrl
  import irq_front_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter int PAGE_W      = 4,
  parameter int ADDR_W      = 6,
  parameter int PIN_PAGE    = 1,
  parameter int TMR_PAGE    = 0,
  parameter int STACK_DEPTH = 4,
  localparam int PC_W       = PAGE_W + ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                tmr_ovf_i,
  input  logic [NUM_PINS-1:0] mask_set_i,
  input  logic [NUM_PINS-1:0] mask_clr_i,
  input  logic                tflag_clr_i,
  input  logic                gie_set_i,
  input  logic                gie_clr_i,
  input  logic                ret_i,
  input  logic                reti_i,
  input  logic [PC_W-1:0]     pc_i,
  output logic                take_o,
  output logic [PC_W-1:0]     vec_o,
  output logic                push_o,
  output logic                gie_o,
  output logic                in_req_o,
  output logic                tmr_req_o,
  output logic                tflag_o,
  output logic [NUM_PINS-1:0] mask_o,
  output logic [NUM_PINS-1:0] pin_lvl_o,
  output logic [PC_W-1:0]     stack_top_o
);
  localparam logic [PC_W-1:0] ADDR_LAST = PC_W'((1 << ADDR_W) - 1);
  localparam logic [PC_W-1:0] PIN_VEC   = PC_W'(PIN_PAGE << ADDR_W) | ADDR_LAST;
  localparam logic [PC_W-1:0] TMR_VEC   = PC_W'(TMR_PAGE << ADDR_W) | ADDR_LAST;

  logic [NUM_PINS-1:0] raise;
  irq_src_e src;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    irq_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (pin_i[p]),
      .mask_set_i (mask_set_i[p]),
      .mask_clr_i (mask_clr_i[p]),
      .lvl_o      (pin_lvl_o[p]),
      .raise_o    (raise[p]),
      .mask_o     (mask_o[p])
    );
  end

  irq_arbiter u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pin_raise_i (|raise),
    .tmr_ovf_i   (tmr_ovf_i),
    .tflag_clr_i (tflag_clr_i),
    .gie_set_i   (gie_set_i),
    .gie_clr_i   (gie_clr_i),
    .reti_i      (reti_i),
    .take_o      (take_o),
    .src_o       (src),
    .gie_o       (gie_o),
    .in_req_o    (in_req_o),
    .tmr_req_o   (tmr_req_o),
    .tflag_o     (tflag_o)
  );

  always_comb begin
    unique case (src)
      SRC_PIN: vec_o = PIN_VEC;
      SRC_TMR: vec_o = TMR_VEC;
      default: vec_o = '0;
    endcase
  end

  assign push_o = take_o;

  irq_pc_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (push_o),
    .pop_i  (ret_i | reti_i),
    .data_i (pc_i),
    .top_o  (stack_top_o)
  );
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int NUM_PINS = 2,
  parameter int PAGE_W   = 4,
  parameter int ADDR_W   = 6,
  parameter int PIN_PAGE = 1,
  parameter int TMR_PAGE = 0,
  localparam int PC_W    = PAGE_W + ADDR_W
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                tmr_ovf_i,
  input logic [NUM_PINS-1:0] mask_set_i,
  input logic                gie_set_i,
  input logic                gie_clr_i,
  input logic                ret_i,
  input logic                reti_i,
  input logic [PC_W-1:0]     pc_i,
  input logic                take_o,
  input logic [PC_W-1:0]     vec_o,
  input logic                gie_o,
  input logic                in_req_o,
  input logic                tmr_req_o,
  input logic                tflag_o,
  input logic [NUM_PINS-1:0] mask_o,
  input logic [PC_W-1:0]     stack_top_o
);
  localparam logic [PC_W-1:0] PIN_T = PC_W'((PIN_PAGE << ADDR_W) + (1 << ADDR_W) - 1);
  localparam logic [PC_W-1:0] TMR_T = PC_W'((TMR_PAGE << ADDR_W) + (1 << ADDR_W) - 1);

  a_r7_take_clears_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !gie_o);

  a_r8_tmr_req_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && in_req_o && tmr_req_o) |=> tmr_req_o);

  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_req_o && !take_o) |=> in_req_o);

  a_r4_mask_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_set_i[0] |=> mask_o[0]);

  a_r5_ovf_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_ovf_i |=> (tflag_o && tmr_req_o));

  a_r9_vec_pin: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && in_req_o) |-> vec_o == PIN_T);

  a_r9_vec_tmr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !in_req_o) |-> vec_o == TMR_T);

  a_r10_push_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !ret_i && !reti_i) |=> stack_top_o == $past(pc_i));

  a_r11_reti_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reti_i && !take_o) |=> gie_o);

  a_r11_ret_keeps_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_i && !reti_i && !take_o && !gie_set_i && !gie_clr_i) |=> gie_o == $past(gie_o));
endmodule

bind irq_front_ctrl irq_front_chk #(
  .NUM_PINS (NUM_PINS),
  .PAGE_W   (PAGE_W),
  .ADDR_W   (ADDR_W),
  .PIN_PAGE (PIN_PAGE),
  .TMR_PAGE (TMR_PAGE)
) chk_i (.*);

// File: tb/irq_front_ctrl_tb_top.sv
module irq_front_ctrl_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic [1:0] pin, mset, mclr;
  logic ovf, tclr, gset, gclr, ret, reti;
  logic [9:0] pc;
  logic take, push, gie, inr, tmr, tf;
  logic [9:0] vec, top;
  logic [1:0] mask, lvl;

  int n_chk = 0;
  int n_bad = 0;

  irq_front_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .tmr_ovf_i(ovf),
    .mask_set_i(mset), .mask_clr_i(mclr), .tflag_clr_i(tclr),
    .gie_set_i(gset), .gie_clr_i(gclr), .ret_i(ret), .reti_i(reti),
    .pc_i(pc), .take_o(take), .vec_o(vec), .push_o(push), .gie_o(gie),
    .in_req_o(inr), .tmr_req_o(tmr), .tflag_o(tf), .mask_o(mask),
    .pin_lvl_o(lvl), .stack_top_o(top)
  );

  typedef struct packed {
    logic [1:0] pin; logic ovf; logic [1:0] mclr; logic tclr; logic gset; logic reti;
    logic [9:0] pc;
    logic e_take; logic [9:0] e_vec; logic e_gie; logic e_inr; logic e_tmr;
    logic [1:0] e_mask; logic e_tf; logic [9:0] e_top;
  } row_t;

  localparam row_t ROWS [10] = '{
    '{2'b00,1'b0,2'b00,1'b0,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b0,1'b0,2'b00,1'b0,10'h000},
    '{2'b01,1'b0,2'b00,1'b0,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b0,1'b0,2'b00,1'b0,10'h000},
    '{2'b01,1'b0,2'b00,1'b0,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b0,1'b0,2'b00,1'b0,10'h000},
    '{2'b01,1'b0,2'b00,1'b0,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b1,1'b0,2'b01,1'b0,10'h000},
    '{2'b01,1'b1,2'b00,1'b0,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b1,1'b1,2'b01,1'b1,10'h000},
    '{2'b00,1'b0,2'b00,1'b0,1'b1,1'b0,10'h055, 1'b1,10'h07F,1'b1,1'b1,1'b1,2'b01,1'b1,10'h000},
    '{2'b00,1'b0,2'b00,1'b0,1'b0,1'b0,10'h123, 1'b0,10'h000,1'b0,1'b0,1'b1,2'b01,1'b1,10'h123},
    '{2'b00,1'b0,2'b00,1'b0,1'b0,1'b1,10'h000, 1'b1,10'h03F,1'b1,1'b0,1'b1,2'b01,1'b1,10'h000},
    '{2'b00,1'b0,2'b00,1'b0,1'b0,1'b0,10'h2AA, 1'b0,10'h000,1'b0,1'b0,1'b0,2'b01,1'b1,10'h2AA},
    '{2'b00,1'b0,2'b01,1'b1,1'b0,1'b0,10'h000, 1'b0,10'h000,1'b0,1'b0,1'b0,2'b00,1'b0,10'h2AA}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic quiet();
    ovf = 0; mset = 0; mclr = 0; tclr = 0; gset = 0; gclr = 0; ret = 0; reti = 0; pc = '0;
  endtask

  task automatic do_reset();
    rst_n = 0; pin = 0; quiet();
    tick(2);
    rst_n = 1;
    tick(1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    // vector walk: R6 R7 R8 R9 R10 R11 R3 R5
    for (int r = 0; r < 10; r++) begin
      pin = ROWS[r].pin; ovf = ROWS[r].ovf; mclr = ROWS[r].mclr; tclr = ROWS[r].tclr;
      gset = ROWS[r].gset; reti = ROWS[r].reti; pc = ROWS[r].pc;
      tick();
      quiet();
      chk("R7 take", take, ROWS[r].e_take);
      chk("R9 vec", vec, ROWS[r].e_vec);
      chk("R7 gie", gie, ROWS[r].e_gie);
      chk("R6 in_req", inr, ROWS[r].e_inr);
      chk("R8 tmr_req", tmr, ROWS[r].e_tmr);
      chk("R3 mask", mask, ROWS[r].e_mask);
      chk("R5 tflag", tf, ROWS[r].e_tf);
      chk("R10 top", top, ROWS[r].e_top);
    end

    // R1 reset clears everything, stack included
    do_reset();
    chk("R1 gie", gie, 0); chk("R1 in_req", inr, 0); chk("R1 tmr_req", tmr, 0);
    chk("R1 tflag", tf, 0); chk("R1 mask", mask, 0); chk("R1 lvl", lvl, 0);
    chk("R1 top", top, 0); chk("R1 take", take, 0);

    // R2 timing and R4 clear colliding with edge
    pin = 2'b10;
    tick(2);
    chk("R2 lvl", lvl, 2'b10);
    chk("R2 no req yet", inr, 0);
    mclr = 2'b10;
    tick();
    mclr = 0;
    chk("R4 mask kept", mask, 2'b10);
    chk("R4 req latched", inr, 1);

    // take it, then R3 masked edge raises nothing
    gset = 1; tick(); gset = 0;
    chk("R7 take pin", take, 1);
    pc = 10'h0AB; tick(); pc = 0;
    chk("R7 req cleared", inr, 0);
    chk("R7 gie cleared", gie, 0);
    pin = 2'b00; tick(3);
    pin = 2'b10; tick(4);
    chk("R3 masked edge", inr, 0);
    chk("R3 mask still set", mask, 2'b10);

    // R5 overflow beats flag clear
    ovf = 1; tclr = 1; tick(); quiet();
    chk("R5 tflag", tf, 1);
    chk("R5 tmr_req", tmr, 1);

    // R8 pin first while timer pending
    pin = 2'b00; mclr = 2'b10; tick(); quiet();
    tick(3);
    pin = 2'b01; tick(3);
    chk("R8 in_req", inr, 1);
    chk("R3 mask pin0", mask, 2'b01);
    gset = 1; tick(); gset = 0;
    chk("R8 pin wins", vec, 10'h07F);
    pc = 10'h111; tick(); pc = 0;
    chk("R8 tmr kept", tmr, 1);
    chk("R10 push 111", top, 10'h111);
    gset = 1; tick(); gset = 0;
    chk("R12 gie_set", gie, 1);
    chk("R9 tmr vec", vec, 10'h03F);
    pc = 10'h222; tick(); pc = 0;
    chk("R10 push 222", top, 10'h222);
    ret = 1; tick(); ret = 0;
    chk("R11 ret pops", top, 10'h111);
    chk("R11 ret no gie", gie, 0);
    ret = 1; tick(); ret = 0;
    chk("R10 pop", top, 10'h0AB);

    // R12 enable set/clear without requests
    gset = 1; tick(); gset = 0;
    chk("R12 set", gie, 1);
    gclr = 1; tick(); gclr = 0;
    chk("R12 clr", gie, 0);

    // R10 depth: five pushes keep the newest four
    for (int k = 1; k <= 5; k++) begin
      ovf = 1; gset = 1; tick(); quiet();
      pc = 10'(k); tick(); pc = 0;
    end
    chk("R10 top5", top, 5);
    for (int k = 4; k >= 1; k--) begin
      ret = 1; tick(); ret = 0;
      chk("R10 pop order", top, (k == 1) ? 0 : k);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule